// File: doc/BRIEF.md
# Mailbox Doorbell Register Unit

This unit lets a host processor and a local processor pass 32-bit messages to each other through two mailbox words. The inbox carries data from the host to the local side. The outbox carries data from the local side to the host. The host reaches every register with whole 32-bit reads and writes. The local processor works through an 8-bit port, choosing a byte lane for each access.

A write to a mailbox, or a read of it by the receiving side, sets a sticky event flag in the status register of the other side. Each side has an enable register that decides which of its status flags may raise its interrupt line. Two more flags in both status registers record target-abort and master-abort events, which arrive as one-cycle pulses. The host also owns a software-reset request bit. That bit shows up in the local status register and can interrupt the local processor.

Only plain read and write strobes are modelled on each side. Read data is combinational from the addressed register and does not depend on the read strobe. The read strobe only marks the access as an event.

Top module: `mbox_doorbell_unit`

## Requirements
- R1: The register select codes are 0 inbox, 1 outbox, 2 host enable, 3 host status, 4 local enable and 5 local status; codes 6 and 7 read as zero. After reset every register reads zero and both interrupt outputs are low.
- R2: A host write to code 0 stores all 32 bits. A local read of lane n returns bits 8n+7..8n. The write sets local status bit 28. A host read of code 0 changes no flag.
- R3: A local write to code 1 updates only the addressed byte lane. Host status bit 28 is set only when lane 3 is written.
- R4: A local read of code 0 sets host status bit 27 only when lane 3 is read; reads of lanes 0 to 2 change no flag.
- R5: A host read of code 1 sets local status bit 27.
- R6: Enable bits sit at bits 28..24 and all other enable bits read zero. The host enable register is written only by the host. The local enable register is written only by the local side, through lane 3, with byte bits 4..0 mapping to bits 28..24. Writes from the other side, or from other lanes, are ignored.
- R7: Writing 1 to status bit 28 or bit 27 clears it; writing 0 leaves it. The host clears through a 32-bit write to code 3. The local side clears through a lane 3 write to code 5, where byte bits 4 and 3 map to bits 28 and 27.
- R8: When a flag's clear and its setting event fall in the same cycle, the flag ends up set.
- R9: A target-abort pulse sets bit 26 and a master-abort pulse sets bit 25, in both status registers. These bits ignore writes and stay set until reset.
- R10: Host enable bit 24 is the software-reset request. It reads back as local status bit 24.
- R11: hostIrq is the registered OR of host status bits 28..25, each ANDed with the matching host enable bit. localIrq is the registered OR of local status bits 28..24, each ANDed with the matching local enable bit. Each output follows its flags one clock later.
- R12: The host cannot write the outbox and the local side cannot write the inbox; such writes change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (marks the read event) |
| hostAddr | input | 3 | Host register select |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data |
| locWrEn | input | 1 | Local write strobe |
| locRdEn | input | 1 | Local read strobe (marks the read event) |
| locAddr | input | 3 | Local register select |
| locByteSel | input | 2 | Local byte lane |
| locWrData | input | 8 | Local write data |
| locRdData | output | 8 | Local read data |
| targetAbortPulse | input | 1 | One-cycle target-abort event |
| masterAbortPulse | input | 1 | One-cycle master-abort event |
| hostIrq | output | 1 | Interrupt toward the host |
| localIrq | output | 1 | Interrupt toward the local processor |

## Verification
The hardest situation to reach is a collision: a status flag is cleared by its owner in the same clock in which the opposite side raises it again. No single access sequence produces it. The bench drives a host inbox write and a local lane 3 clear together in one cycle, with the flag already set. It then compares the result against a lone clear. The one-clock interrupt delay is checked by sampling each interrupt in the cycle right after its flag is set, where it must still be low, and again one cycle later. This is repeated for every event source.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int REG_SEL_W = 3;

  // register select codes
  localparam logic [REG_SEL_W-1:0] SEL_INBOX   = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_OUTBOX  = 3'd1;
  localparam logic [REG_SEL_W-1:0] SEL_HOST_EN = 3'd2;
  localparam logic [REG_SEL_W-1:0] SEL_HOST_ST = 3'd3;
  localparam logic [REG_SEL_W-1:0] SEL_LOC_EN  = 3'd4;
  localparam logic [REG_SEL_W-1:0] SEL_LOC_ST  = 3'd5;

  // event field: bits EVT_LO .. EVT_LO+EVT_N-1 of every control/status word
  localparam int EVT_LO = 24;
  localparam int EVT_N  = 5;
  // index inside the event field
  localparam int IDX_PEER_WR = 4;  // bit 28
  localparam int IDX_PEER_RD = 3;  // bit 27
  localparam int IDX_TABORT  = 2;  // bit 26
  localparam int IDX_MABORT  = 1;  // bit 25
  localparam int IDX_SWRST   = 0;  // bit 24

  typedef struct packed {
    logic hInboxWr;     // host writes inbox
    logic hOutboxRd;    // host reads outbox
    logic hEnWr;        // host writes its enable register
    logic hStClr;       // host write-1-to-clear on its status
    logic lOutboxWr;    // local writes one outbox lane
    logic lOutboxEvt;   // local writes final outbox lane
    logic lInboxRdEvt;  // local reads final inbox lane
    logic lEnWr;        // local writes its enable register
    logic lStClr;       // local write-1-to-clear on its status
  } mboxStrobes_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W   = $clog2(LANES),
  localparam int EVT_LANE = EVT_LO / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic [REG_SEL_W-1:0] hostAddr,
  input  logic                 locWrEn,
  input  logic                 locRdEn,
  input  logic [REG_SEL_W-1:0] locAddr,
  input  logic [LANE_W-1:0]    locByteSel,
  output mboxStrobes_t         stb
);

  logic lastLane;
  logic evtLane;

  assign lastLane = (locByteSel == LANE_W'(LANES - 1));
  assign evtLane  = (locByteSel == LANE_W'(EVT_LANE));

  always_comb begin
    stb = '0;
    stb.hInboxWr    = hostWrEn && (hostAddr == SEL_INBOX);
    stb.hOutboxRd   = hostRdEn && (hostAddr == SEL_OUTBOX);
    stb.hEnWr       = hostWrEn && (hostAddr == SEL_HOST_EN);
    stb.hStClr      = hostWrEn && (hostAddr == SEL_HOST_ST);
    stb.lOutboxWr   = locWrEn  && (locAddr == SEL_OUTBOX);
    stb.lOutboxEvt  = locWrEn  && (locAddr == SEL_OUTBOX) && lastLane;
    stb.lInboxRdEvt = locRdEn  && (locAddr == SEL_INBOX) && lastLane;
    stb.lEnWr       = locWrEn  && (locAddr == SEL_LOC_EN) && evtLane;
    stb.lStClr      = locWrEn  && (locAddr == SEL_LOC_ST) && evtLane;
  end

  // R3
  early_lane_noevt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locWrEn && locAddr == SEL_OUTBOX && locByteSel != LANE_W'(LANES - 1)) |-> !stb.lOutboxEvt);

  // R4
  early_lane_nord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locRdEn && locByteSel != LANE_W'(LANES - 1)) |-> !stb.lInboxRdEvt);

  // R12
  cross_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locWrEn && locAddr == SEL_INBOX) |-> !(stb.lOutboxWr || stb.lEnWr || stb.lStClr));

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES   = DATA_W / BYTE_W,
  localparam int LANE_W  = $clog2(LANES),
  localparam int EVT_OFS = EVT_LO % BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  mboxStrobes_t         stb,
  input  logic [DATA_W-1:0]    hostWrData,
  input  logic [REG_SEL_W-1:0] hostAddr,
  output logic [DATA_W-1:0]    hostRdData,
  input  logic [BYTE_W-1:0]    locWrData,
  input  logic [REG_SEL_W-1:0] locAddr,
  input  logic [LANE_W-1:0]    locByteSel,
  output logic [BYTE_W-1:0]    locRdData,
  input  logic                 targetAbortPulse,
  input  logic                 masterAbortPulse,
  output logic                 hostIrq,
  output logic                 localIrq
);

  logic [DATA_W-1:0] inbox;
  logic [DATA_W-1:0] outbox;
  logic [EVT_N-1:0]  hostEn;
  logic [EVT_N-1:0]  locEn;
  logic              hPeerWr, hPeerRd;   // host status sticky flags
  logic              lPeerWr, lPeerRd;   // local status sticky flags
  logic              taSeen, maSeen;     // shared abort flags
  logic [EVT_N-1:0]  hostSt, locSt;
  logic [EVT_N-1:0]  hClrMask, lClrMask;
  logic [DATA_W-1:0] locWord;

  function automatic logic [DATA_W-1:0] placeEvt(input logic [EVT_N-1:0] v);
    return {{(DATA_W-EVT_LO-EVT_N){1'b0}}, v, {EVT_LO{1'b0}}};
  endfunction

  assign hClrMask = stb.hStClr ? hostWrData[EVT_LO +: EVT_N] : '0;
  assign lClrMask = stb.lStClr ? locWrData[EVT_OFS +: EVT_N] : '0;

  assign hostSt = {hPeerWr, hPeerRd, taSeen, maSeen, 1'b0};
  assign locSt  = {lPeerWr, lPeerRd, taSeen, maSeen, hostEn[IDX_SWRST]};

  // mailbox words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            inbox <= '0;
    else if (stb.hInboxWr) inbox <= hostWrData;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_outLane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        outbox[g*BYTE_W +: BYTE_W] <= '0;
      else if (stb.lOutboxWr && locByteSel == LANE_W'(g))
        outbox[g*BYTE_W +: BYTE_W] <= locWrData;
    end
  end

  // enable registers, each owned by one side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hostEn <= '0;
      locEn  <= '0;
    end else begin
      if (stb.hEnWr) hostEn <= hostWrData[EVT_LO +: EVT_N];
      if (stb.lEnWr) locEn  <= locWrData[EVT_OFS +: EVT_N];
    end
  end

  // sticky flags: a new event overrides a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hPeerWr <= 1'b0;
      hPeerRd <= 1'b0;
      lPeerWr <= 1'b0;
      lPeerRd <= 1'b0;
      taSeen  <= 1'b0;
      maSeen  <= 1'b0;
    end else begin
      hPeerWr <= stb.lOutboxEvt  | (hPeerWr & ~hClrMask[IDX_PEER_WR]);
      hPeerRd <= stb.lInboxRdEvt | (hPeerRd & ~hClrMask[IDX_PEER_RD]);
      lPeerWr <= stb.hInboxWr    | (lPeerWr & ~lClrMask[IDX_PEER_WR]);
      lPeerRd <= stb.hOutboxRd   | (lPeerRd & ~lClrMask[IDX_PEER_RD]);
      taSeen  <= taSeen | targetAbortPulse;
      maSeen  <= maSeen | masterAbortPulse;
    end
  end

  // registered interrupt outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hostIrq  <= 1'b0;
      localIrq <= 1'b0;
    end else begin
      hostIrq  <= |(hostSt[EVT_N-1:1] & hostEn[EVT_N-1:1]);
      localIrq <= |(locSt & locEn);
    end
  end

  // read paths
  always_comb begin
    case (hostAddr)
      SEL_INBOX:   hostRdData = inbox;
      SEL_OUTBOX:  hostRdData = outbox;
      SEL_HOST_EN: hostRdData = placeEvt(hostEn);
      SEL_HOST_ST: hostRdData = placeEvt(hostSt);
      SEL_LOC_EN:  hostRdData = placeEvt(locEn);
      SEL_LOC_ST:  hostRdData = placeEvt(locSt);
      default:     hostRdData = '0;
    endcase
  end

  always_comb begin
    case (locAddr)
      SEL_INBOX:   locWord = inbox;
      SEL_OUTBOX:  locWord = outbox;
      SEL_HOST_EN: locWord = placeEvt(hostEn);
      SEL_HOST_ST: locWord = placeEvt(hostSt);
      SEL_LOC_EN:  locWord = placeEvt(locEn);
      SEL_LOC_ST:  locWord = placeEvt(locSt);
      default:     locWord = '0;
    endcase
  end

  assign locRdData = locWord[locByteSel*BYTE_W +: BYTE_W];

  // R2
  inbox_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hInboxWr |=> lPeerWr);

  // R4
  inbox_rd_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.lInboxRdEvt |=> hPeerRd);

  // R5
  outbox_rd_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hOutboxRd |=> lPeerRd);

  // R6
  host_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.hEnWr |=> $stable(hostEn));

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.lStClr && locWrData[EVT_OFS + IDX_PEER_WR] && stb.hInboxWr) |=> lPeerWr);

  // R9
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taSeen || targetAbortPulse) |=> taSeen);

  // R11
  local_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(locSt & locEn)) |=> !localIrq);

endmodule

// File: rtl/mbox_doorbell_unit.sv
module mbox_doorbell_unit
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic [REG_SEL_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]    hostWrData,
  output logic [DATA_W-1:0]    hostRdData,
  input  logic                 locWrEn,
  input  logic                 locRdEn,
  input  logic [REG_SEL_W-1:0] locAddr,
  input  logic [LANE_W-1:0]    locByteSel,
  input  logic [BYTE_W-1:0]    locWrData,
  output logic [BYTE_W-1:0]    locRdData,
  input  logic                 targetAbortPulse,
  input  logic                 masterAbortPulse,
  output logic                 hostIrq,
  output logic                 localIrq
);

  mboxStrobes_t stb;

  mbox_ctrl #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .hostAddr   (hostAddr),
    .locWrEn    (locWrEn),
    .locRdEn    (locRdEn),
    .locAddr    (locAddr),
    .locByteSel (locByteSel),
    .stb        (stb)
  );

  mbox_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk              (clk),
    .rst_n            (rst_n),
    .stb              (stb),
    .hostWrData       (hostWrData),
    .hostAddr         (hostAddr),
    .hostRdData       (hostRdData),
    .locWrData        (locWrData),
    .locAddr          (locAddr),
    .locByteSel       (locByteSel),
    .locRdData        (locRdData),
    .targetAbortPulse (targetAbortPulse),
    .masterAbortPulse (masterAbortPulse),
    .hostIrq          (hostIrq),
    .localIrq         (localIrq)
  );

endmodule

// File: tb/test_mbox_doorbell_unit.sv
`timescale 1ns/1ps
module test_mbox_doorbell_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hostWrEn, hostRdEn;
  logic [2:0]  hostAddr;
  logic [31:0] hostWrData, hostRdData;
  logic        locWrEn, locRdEn;
  logic [2:0]  locAddr;
  logic [1:0]  locByteSel;
  logic [7:0]  locWrData, locRdData;
  logic        targetAbortPulse, masterAbortPulse;
  logic        hostIrq, localIrq;

  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  mbox_doorbell_unit i_mbox_doorbell_unit (
    .clk(clk), .rst_n(rst_n),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .locWrEn(locWrEn), .locRdEn(locRdEn), .locAddr(locAddr),
    .locByteSel(locByteSel), .locWrData(locWrData), .locRdData(locRdData),
    .targetAbortPulse(targetAbortPulse), .masterAbortPulse(masterAbortPulse),
    .hostIrq(hostIrq), .localIrq(localIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    tick();
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [31:0] d);
    hostAddr = a; hostRdEn = 1'b1;
    #1 d = hostRdData;
    tick();
    hostRdEn = 1'b0;
  endtask

  task automatic hostPeek(input logic [2:0] a, output logic [31:0] d);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic locWrite(input logic [2:0] a, input logic [1:0] lane, input logic [7:0] b);
    locAddr = a; locByteSel = lane; locWrData = b; locWrEn = 1'b1;
    tick();
    locWrEn = 1'b0;
  endtask

  task automatic locRead(input logic [2:0] a, input logic [1:0] lane, output logic [7:0] b);
    locAddr = a; locByteSel = lane; locRdEn = 1'b1;
    #1 b = locRdData;
    tick();
    locRdEn = 1'b0;
  endtask

  task automatic locPeek(input logic [2:0] a, input logic [1:0] lane, output logic [7:0] b);
    locAddr = a; locByteSel = lane;
    #1 b = locRdData;
  endtask

  // checks one-cycle latency: low right after the flag edge, high one cycle later
  task automatic irqRise(input string req, input logic isHost);
    check({req, " irq still low"}, 32'(isHost ? hostIrq : localIrq), 32'd0);
    @(negedge clk);
    check({req, " irq high"}, 32'(isHost ? hostIrq : localIrq), 32'd1);
  endtask

  task automatic irqFall(input string req, input logic isHost);
    @(negedge clk);
    check({req, " irq dropped"}, 32'(isHost ? hostIrq : localIrq), 32'd0);
  endtask

  task automatic pulseAbort(input logic ta);
    if (ta) targetAbortPulse = 1'b1; else masterAbortPulse = 1'b1;
    tick();
    targetAbortPulse = 1'b0; masterAbortPulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic [31:0] lastPat;
    hostWrEn = 0; hostRdEn = 0; hostAddr = 0; hostWrData = 0;
    locWrEn = 0; locRdEn = 0; locAddr = 0; locByteSel = 0; locWrData = 0;
    targetAbortPulse = 0; masterAbortPulse = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state over every select code
    check("R1 hostIrq", 32'(hostIrq), 0);
    check("R1 localIrq", 32'(localIrq), 0);
    for (int a = 0; a < 8; a++) begin
      hostPeek(3'(a), d);
      check("R1 reset value", d, 0);
    end

    // R2 inbox sweep with computed patterns, every lane
    lastPat = 0;
    for (int k = 0; k < 8; k++) begin
      lastPat = (32'h01020304 * 32'(k + 1)) ^ (32'hF0F0F0F0 >> k);
      hostWrite(0, lastPat);
      hostPeek(5, d);
      check("R2 inbox write flag", d, 32'h1000_0000);
      for (int lane = 0; lane < 4; lane++) begin
        locPeek(0, 2'(lane), b);
        check("R2 inbox lane", 32'(b), 32'((lastPat >> (8 * lane)) & 32'hFF));
      end
      hostRead(0, d);
      check("R2 host inbox readback", d, lastPat);
      hostPeek(5, d);
      check("R2 host inbox read no event", d, 32'h1000_0000);
      hostPeek(3, d);
      check("R2 host status untouched", d, 0);
      locWrite(5, 3, 8'h10);
      hostPeek(5, d);
      check("R7 local clear bit 28", d, 0);
    end

    // R4 only the final lane read signals the host
    for (int lane = 0; lane < 3; lane++) begin
      locRead(0, 2'(lane), b);
      hostPeek(3, d);
      check("R4 early lane read no flag", d, 0);
    end
    locRead(0, 3, b);
    hostPeek(3, d);
    check("R4 final lane read flag", d, 32'h0800_0000);
    hostWrite(3, 32'h0800_0000);
    hostPeek(3, d);
    check("R7 host clear bit 27", d, 0);

    // R3 outbox lane writes
    for (int lane = 0; lane < 3; lane++) begin
      locWrite(1, 2'(lane), 8'(8'h11 * (lane + 1)));
      hostPeek(3, d);
      check("R3 early lane write no flag", d, 0);
    end
    hostPeek(1, d);
    check("R3 partial outbox", d, 32'h0033_2211);
    locWrite(1, 3, 8'h44);
    hostPeek(3, d);
    check("R3 final lane write flag", d, 32'h1000_0000);
    hostPeek(1, d);
    check("R3 full outbox", d, 32'h4433_2211);

    // R5 host read of outbox
    hostRead(1, d);
    hostPeek(5, d);
    check("R5 outbox read flag", d, 32'h0800_0000);

    // R12 writes from the wrong side
    hostWrite(1, 32'hDEAD_BEEF);
    hostPeek(1, d);
    check("R12 host write outbox ignored", d, 32'h4433_2211);
    hostPeek(3, d);
    check("R12 host status after ignored write", d, 32'h1000_0000);
    locWrite(0, 3, 8'h77);
    hostPeek(0, d);
    check("R12 local write inbox ignored", d, lastPat);
    hostPeek(5, d);
    check("R12 local status after ignored write", d, 32'h0800_0000);

    // R7 writing zero leaves the flag
    hostWrite(3, 32'h0);
    hostPeek(3, d);
    check("R7 host write zero keeps", d, 32'h1000_0000);
    hostWrite(3, 32'h1000_0000);
    hostPeek(3, d);
    check("R7 host clear", d, 0);
    locWrite(5, 3, 8'h00);
    hostPeek(5, d);
    check("R7 local write zero keeps", d, 32'h0800_0000);
    locWrite(5, 3, 8'h08);
    hostPeek(5, d);
    check("R7 local clear bit 27", d, 0);

    // R8 clear and set in the same cycle
    hostWrite(0, lastPat);
    hostAddr = 0; hostWrData = lastPat; hostWrEn = 1'b1;
    locAddr = 5; locByteSel = 3; locWrData = 8'h10; locWrEn = 1'b1;
    tick();
    hostWrEn = 1'b0; locWrEn = 1'b0;
    hostPeek(5, d);
    check("R8 event wins over clear", d, 32'h1000_0000);
    locWrite(5, 3, 8'h10);
    hostPeek(5, d);
    check("R8 lone clear afterwards", d, 0);

    // R6 ownership of enable registers
    locWrite(2, 3, 8'hFF);
    hostPeek(2, d);
    check("R6 local cannot write host enable", d, 0);
    hostWrite(4, 32'hFFFF_FFFF);
    hostPeek(4, d);
    check("R6 host cannot write local enable", d, 0);
    locWrite(4, 0, 8'hFF);
    hostPeek(4, d);
    check("R6 local enable other lane ignored", d, 0);
    hostWrite(2, 32'hFFFF_FFFF);
    hostPeek(2, d);
    check("R6 host enable mask", d, 32'h1F00_0000);
    hostPeek(5, d);
    check("R10 software reset mirrored", d, 32'h0100_0000);
    locWrite(4, 3, 8'hFF);
    hostPeek(4, d);
    check("R6 local enable mask", d, 32'h1F00_0000);
    hostWrite(2, 32'h0);
    locWrite(4, 3, 8'h00);
    tick();
    check("R11 irqs idle", 32'({hostIrq, localIrq}), 0);

    // R11 local interrupt per source
    locWrite(4, 3, 8'h10);
    hostWrite(0, 32'h1234_5678);
    irqRise("R11 inbox write", 1'b0);
    locWrite(5, 3, 8'h10);
    irqFall("R11 inbox write", 1'b0);

    locWrite(4, 3, 8'h08);
    hostRead(1, d);
    irqRise("R11 outbox read", 1'b0);
    locWrite(5, 3, 8'h08);
    irqFall("R11 outbox read", 1'b0);

    locWrite(4, 3, 8'h01);
    hostWrite(2, 32'h0100_0000);
    irqRise("R10 software reset", 1'b0);
    hostWrite(2, 32'h0);
    irqFall("R10 software reset", 1'b0);

    locWrite(4, 3, 8'h00);
    hostWrite(0, 32'h1);
    tick();
    check("R11 disabled source silent", 32'(localIrq), 0);
    locWrite(5, 3, 8'h10);

    // R11 host interrupt per source
    hostWrite(2, 32'h1000_0000);
    locWrite(1, 3, 8'h55);
    irqRise("R11 outbox write", 1'b1);
    hostWrite(3, 32'h1000_0000);
    irqFall("R11 outbox write", 1'b1);

    hostWrite(2, 32'h0800_0000);
    locRead(0, 3, b);
    irqRise("R11 inbox read", 1'b1);
    hostWrite(3, 32'h0800_0000);
    irqFall("R11 inbox read", 1'b1);

    // R9 abort flags, sticky and read-only
    hostWrite(2, 32'h0400_0000);
    locWrite(4, 3, 8'h02);
    pulseAbort(1'b1);
    hostPeek(3, d);
    check("R9 target abort host", d, 32'h0400_0000);
    hostPeek(5, d);
    check("R9 target abort local", d, 32'h0400_0000);
    irqRise("R9 target abort", 1'b1);
    check("R11 local not enabled for target abort", 32'(localIrq), 0);
    pulseAbort(1'b0);
    hostPeek(3, d);
    check("R9 master abort host", d, 32'h0600_0000);
    irqRise("R9 master abort", 1'b0);
    hostWrite(3, 32'hFFFF_FFFF);
    hostPeek(3, d);
    check("R9 host write cannot clear", d, 32'h0600_0000);
    locWrite(5, 3, 8'hFF);
    hostPeek(5, d);
    check("R9 local write cannot clear", d, 32'h0600_0000);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule